// File: doc/BRIEF.md
# Analog and Power-Management Register Window

This block is a 64 KiB register window on a simple request/response register bus. It holds three regions. The first is a bank of PLL and analog control registers. The second is a bank of power-management registers. The third is a single read-only chip identification word. Each access gets one response. An address that lands in a bank selects one 16-byte slot. Address bits [3:2] inside that slot pick how a write combines with the stored value: plain write, set bits, clear bits or toggle bits. A read from any of the four aliases returns the stored value.

By default the power-management bank spans far enough to cover the identification word's address. The decoder resolves that overlap in favour of the identification word. Reset loads the PLL bank with fixed non-zero defaults, and bit 31 (the lock indicator) is forced high in every PLL control register. A control FSM with two states handles the handshake. In `ST_IDLE` the block accepts a request when `req_valid` is high; accepting moves it to `ST_RESP`. In `ST_RESP` it presents the response for exactly one cycle and then always returns to `ST_IDLE`.

Top module: `analog_pmu_window`

## Requirements
- R1: After reset, PLL bank slot k (byte offset 0x60 + 16·k) reads its default value. Slot 0 reads 0x80002042, slot 3 reads 0x06AAAC4D and slot 8 reads 0x80001FC0. The spread-spectrum slot 2 and every slot from 18 to 25 read 0. The lock indicator (bit 31) is set in control slots 0, 1, 5, 6, 7, 8, 9, 13 and 17.
- R2: Every power-management slot (byte offset 0x200 + 16·k, k = 0..127) reads 0 after reset.
- R3: Inside a bank slot, address bits [3:2] select the write operation: 0 replaces the value, 1 ORs the write data in, 2 clears the bits that are set in the write data, and 3 XORs the write data in. A read at any of the four aliases returns the stored value with no error.
- R4: A read at offset 0x800 returns 0x00720010 with no error.
- R5: A write at offset 0x800 reports an error and leaves the value read there at 0x00720010.
- R6: Offset 0x800 decodes to the identification word even though power-management slot 96 covers it. Offsets 0x804, 0x808 and 0x80C still reach slot 96 through its set, clear and toggle aliases.
- R7: An address outside all regions (below 0x60, or at or above 0xA00 apart from 0x800) returns read data 0 and reports an error. A write to such an address changes no register.
- R8: An access whose address bits [1:0] are not 00 reports an error, returns read data 0 and changes no register.
- R9: In `ST_IDLE`, `req_ready` is high and `rsp_valid` is low. The cycle after a request is accepted, `rsp_valid` is high for exactly one cycle and `req_ready` is low. A write response carries read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (high in `ST_IDLE`) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present (high in `ST_RESP`) |
| rsp_rdata | output | 32 | Read data; 0 for writes and errors |
| rsp_err | output | 1 | Access rejected: unmapped, misaligned or identification write |

## Verification
The bench targets the overlap at 0x800. A decoder that checked the bank ranges before the identification word would return 0 there and let writes land in slot 96. A decoder that matched the whole 16-byte slot would hide slot 96's set alias at 0x804. The bench reads back the spread-spectrum, numerator and tail slots of the PLL bank. A design that set the lock bit everywhere, or nowhere, would give wrong values. The bench writes to addresses just outside both banks and to misaligned offsets, then reads the neighbouring registers. A decoder with an off-by-one range limit, or one that ignored bits [1:0], would corrupt those registers.

// File: rtl/anawin_pkg.sv
package anawin_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_PLL  = 2'd1,
        RG_PMU  = 2'd2,
        RG_ID   = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } alias_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

    localparam logic [DATA_W-1:0] LOCK_FLAG  = 32'h8000_0000;
    localparam logic [DATA_W-1:0] CHIP_IDENT = 32'h0072_0010;

    // Base default per PLL bank slot, before the lock flag.
    function automatic logic [DATA_W-1:0] pll_base_value(input int unsigned slot);
        case (slot)
            0:       return 32'h0000_2042;
            1:       return 32'h0060_302C;
            3:       return 32'h06AA_AC4D;
            4:       return 32'h1000_03EC;
            5:       return 32'h0000_2000;
            6:       return 32'h5260_5A56;
            7:       return 32'h5252_5216;
            8:       return 32'h0000_1FC0;
            9:       return 32'h0001_301B;
            11:      return 32'h05F5_E100;
            12:      return 32'h2964_619C;
            13:      return 32'h0008_201B;
            15:      return 32'h0000_F699;
            16:      return 32'h000F_4240;
            default: return '0;
        endcase
    endfunction

    function automatic bit pll_has_lock(input int unsigned slot);
        case (slot)
            0, 1, 5, 6, 7, 8, 9, 13, 17: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pll_reset_value(input int unsigned slot);
        return pll_base_value(slot) | (pll_has_lock(slot) ? LOCK_FLAG : '0);
    endfunction

endpackage

// File: rtl/anawin_decode.sv
module anawin_decode
    import anawin_pkg::*;
#(
    parameter int AW       = 16,
    parameter int PLL_BASE = 32'h60,
    parameter int PLL_REGS = 26,
    parameter int PMU_BASE = 32'h200,
    parameter int PMU_REGS = 128,
    parameter int ID_OFF   = 32'h800,
    parameter int PLL_IW   = $clog2(PLL_REGS),
    parameter int PMU_IW   = $clog2(PMU_REGS)
) (
    input  logic [AW-1:0]     addr,
    output region_e           region,
    output logic [PLL_IW-1:0] pll_idx,
    output logic [PMU_IW-1:0] pmu_idx,
    output alias_op_e         op
);
    localparam int SLOT_BYTES = 16;
    localparam int PLL_END    = PLL_BASE + PLL_REGS * SLOT_BYTES;
    localparam int PMU_END    = PMU_BASE + PMU_REGS * SLOT_BYTES;

    logic [31:0] a_ext;
    logic        aligned;

    always_comb begin
        a_ext   = 32'(addr);
        aligned = (addr[1:0] == 2'b00);
        op      = alias_op_e'(addr[3:2]);
        pll_idx = PLL_IW'((a_ext - 32'(PLL_BASE)) >> 4);
        pmu_idx = PMU_IW'((a_ext - 32'(PMU_BASE)) >> 4);
        // Priority: alignment, then identification word, then banks.
        if (!aligned)
            region = RG_NONE;
        else if (a_ext == 32'(ID_OFF))
            region = RG_ID;
        else if (a_ext >= 32'(PLL_BASE) && a_ext < 32'(PLL_END))
            region = RG_PLL;
        else if (a_ext >= 32'(PMU_BASE) && a_ext < 32'(PMU_END))
            region = RG_PMU;
        else
            region = RG_NONE;
    end

    // R8
    always_comb begin
        if (addr[1:0] != 2'b00)
            misalign_none_chk: assert (region == RG_NONE);
    end

endmodule

// File: rtl/anawin_bank.sv
module anawin_bank
    import anawin_pkg::*;
#(
    parameter int N            = 26,
    parameter bit PLL_DEFAULTS = 1'b1,
    parameter int IW           = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     idx,
    input  alias_op_e         op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] q [N];
    logic [DATA_W-1:0] upd;
    logic [DATA_W-1:0] cur;

    always_comb begin
        cur = '0;
        for (int i = 0; i < N; i++)
            if (idx == IW'(i)) cur = q[i];
    end

    always_comb begin
        unique case (op)
            OP_WRITE: upd = wdata;
            OP_SET:   upd = cur | wdata;
            OP_CLR:   upd = cur & ~wdata;
            OP_TOG:   upd = cur ^ wdata;
            default:  upd = cur;
        endcase
    end

    for (genvar g = 0; g < N; g++) begin : g_reg
        localparam logic [DATA_W-1:0] RV = PLL_DEFAULTS ? pll_reset_value(g) : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[g] <= RV;
            else if (we && idx == IW'(g))
                q[g] <= upd;
        end
    end

    assign rdata = cur;

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_SET) |=> ((q[$past(idx)] & $past(wdata)) == $past(wdata)));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_CLR) |=> ((q[$past(idx)] & $past(wdata)) == '0));

    // R3
    write_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_WRITE) |=> (q[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/analog_pmu_window.sv
module analog_pmu_window
    import anawin_pkg::*;
#(
    parameter int AW       = 16,
    parameter int PLL_BASE = 32'h60,
    parameter int PLL_REGS = 26,
    parameter int PMU_BASE = 32'h200,
    parameter int PMU_REGS = 128,
    parameter int ID_OFF   = 32'h800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    output logic          rsp_err
);
    localparam int PLL_IW = $clog2(PLL_REGS);
    localparam int PMU_IW = $clog2(PMU_REGS);

    state_e            state_q, state_d;
    region_e           region;
    alias_op_e         op;
    logic [PLL_IW-1:0] pll_idx;
    logic [PMU_IW-1:0] pmu_idx;
    logic [DATA_W-1:0] pll_rd, pmu_rd, rd_mux;
    logic              accept, err_d, pll_we, pmu_we;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    anawin_decode #(
        .AW(AW), .PLL_BASE(PLL_BASE), .PLL_REGS(PLL_REGS),
        .PMU_BASE(PMU_BASE), .PMU_REGS(PMU_REGS), .ID_OFF(ID_OFF),
        .PLL_IW(PLL_IW), .PMU_IW(PMU_IW)
    ) u_decode (
        .addr(req_addr), .region(region),
        .pll_idx(pll_idx), .pmu_idx(pmu_idx), .op(op)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign pll_we = accept && req_write && (region == RG_PLL);
    assign pmu_we = accept && req_write && (region == RG_PMU);

    anawin_bank #(.N(PLL_REGS), .PLL_DEFAULTS(1'b1), .IW(PLL_IW)) u_pll_bank (
        .clk(clk), .rst_n(rst_n), .we(pll_we), .idx(pll_idx),
        .op(op), .wdata(req_wdata), .rdata(pll_rd)
    );

    anawin_bank #(.N(PMU_REGS), .PLL_DEFAULTS(1'b0), .IW(PMU_IW)) u_pmu_bank (
        .clk(clk), .rst_n(rst_n), .we(pmu_we), .idx(pmu_idx),
        .op(op), .wdata(req_wdata), .rdata(pmu_rd)
    );

    always_comb begin
        unique case (region)
            RG_PLL:  rd_mux = pll_rd;
            RG_PMU:  rd_mux = pmu_rd;
            RG_ID:   rd_mux = CHIP_IDENT;
            default: rd_mux = '0;
        endcase
        err_d = (region == RG_NONE) || (region == RG_ID && req_write);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Response outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            rdata_q <= req_write ? '0 : rd_mux;
            err_q   <= err_d;
        end else begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_rdata = rdata_q;
    assign rsp_err   = err_q;

    // R9
    rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && !req_ready));

    // R8
    misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_addr[1:0] != 2'b00) |=> (rsp_err && rsp_rdata == '0));

    // R5
    id_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && 32'(req_addr) == 32'(ID_OFF)) |=> rsp_err);

    // R7
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

endmodule

// File: tb/analog_pmu_window_bench.sv
`timescale 1ns/1ps
module analog_pmu_window_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    analog_pmu_window u_analog_pmu_window (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    // {tag, write, addr, wdata, expected rdata, expected err}
    localparam int NV = 33;
    localparam logic [85:0] VEC [NV] = '{
        {4'd1, 1'b0, 16'h0060, 32'h0, 32'h8000_2042, 1'b0}, // R1 slot 0
        {4'd1, 1'b0, 16'h00E0, 32'h0, 32'h8000_1FC0, 1'b0}, // R1 slot 8
        {4'd1, 1'b0, 16'h0080, 32'h0, 32'h0000_0000, 1'b0}, // R1 spread slot
        {4'd1, 1'b0, 16'h0090, 32'h0, 32'h06AA_AC4D, 1'b0}, // R1 no lock
        {4'd1, 1'b0, 16'h01F0, 32'h0, 32'h0000_0000, 1'b0}, // R1 last slot
        {4'd2, 1'b0, 16'h0200, 32'h0, 32'h0000_0000, 1'b0}, // R2
        {4'd2, 1'b0, 16'h09F0, 32'h0, 32'h0000_0000, 1'b0}, // R2 last
        {4'd3, 1'b1, 16'h0210, 32'hA5A5_0000, 32'h0, 1'b0}, // R3 write
        {4'd3, 1'b1, 16'h0214, 32'h0000_00FF, 32'h0, 1'b0}, // R3 set
        {4'd3, 1'b0, 16'h0218, 32'h0, 32'hA5A5_00FF, 1'b0}, // R3 alias read
        {4'd3, 1'b1, 16'h0218, 32'hA000_000F, 32'h0, 1'b0}, // R3 clear
        {4'd3, 1'b0, 16'h0210, 32'h0, 32'h05A5_00F0, 1'b0}, // R3
        {4'd3, 1'b1, 16'h021C, 32'hFFFF_0000, 32'h0, 1'b0}, // R3 toggle
        {4'd3, 1'b0, 16'h021C, 32'h0, 32'hFA5A_00F0, 1'b0}, // R3
        {4'd3, 1'b1, 16'h0068, 32'h8000_0000, 32'h0, 1'b0}, // R3 clear lock
        {4'd3, 1'b0, 16'h0060, 32'h0, 32'h0000_2042, 1'b0}, // R3
        {4'd4, 1'b0, 16'h0800, 32'h0, 32'h0072_0010, 1'b0}, // R4
        {4'd5, 1'b1, 16'h0800, 32'h1234_5678, 32'h0, 1'b1}, // R5
        {4'd5, 1'b0, 16'h0800, 32'h0, 32'h0072_0010, 1'b0}, // R5
        {4'd6, 1'b1, 16'h0804, 32'h0000_0F0F, 32'h0, 1'b0}, // R6 set alias
        {4'd6, 1'b0, 16'h080C, 32'h0, 32'h0000_0F0F, 1'b0}, // R6
        {4'd6, 1'b0, 16'h0800, 32'h0, 32'h0072_0010, 1'b0}, // R6
        {4'd7, 1'b1, 16'h005C, 32'hFFFF_FFFF, 32'h0, 1'b1}, // R7 below bank
        {4'd7, 1'b0, 16'h0064, 32'h0, 32'h0000_2042, 1'b0}, // R7 untouched
        {4'd7, 1'b0, 16'h0000, 32'h0, 32'h0000_0000, 1'b1}, // R7
        {4'd7, 1'b1, 16'h0A00, 32'h0000_0001, 32'h0, 1'b1}, // R7 above bank
        {4'd7, 1'b0, 16'h09F0, 32'h0, 32'h0000_0000, 1'b0}, // R7 untouched
        {4'd7, 1'b0, 16'hFFFC, 32'h0, 32'h0000_0000, 1'b1}, // R7 top
        {4'd8, 1'b1, 16'h0201, 32'hFFFF_FFFF, 32'h0, 1'b1}, // R8
        {4'd8, 1'b0, 16'h0200, 32'h0, 32'h0000_0000, 1'b0}, // R8 untouched
        {4'd8, 1'b0, 16'h0212, 32'h0, 32'h0000_0000, 1'b1}, // R8 misaligned read
        {4'd8, 1'b1, 16'h0066, 32'hFFFF_FFFF, 32'h0, 1'b1}, // R8
        {4'd8, 1'b0, 16'h0060, 32'h0, 32'h0000_2042, 1'b0}  // R8 untouched
    };

    task automatic chk(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [15:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic er);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // R9: response present, not ready
        chk(rsp_valid === 1'b1 && req_ready === 1'b0, 9, {30'b0, rsp_valid, req_ready}, 32'h2);
        rd = rsp_rdata;
        er = rsp_err;
        @(negedge clk);
        // R9: back to idle after one cycle
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, 9, {30'b0, rsp_valid, req_ready}, 32'h1);
    endtask

    initial begin
        logic [31:0] rd;
        logic        er;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(req_ready === 1'b1 && rsp_valid === 1'b0, 9, {30'b0, rsp_valid, req_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0, 9, {30'b0, rsp_valid, req_ready}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][81], VEC[i][80:65], VEC[i][64:33], rd, er);
            chk(rd === VEC[i][32:1], int'(VEC[i][85:82]), rd, VEC[i][32:1]);
            chk(er === VEC[i][0], int'(VEC[i][85:82]), {31'b0, er}, {31'b0, VEC[i][0]});
        end

        // R1, R2: a second reset restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 16'h0060, 32'h0, rd, er);
        chk(rd === 32'h8000_2042, 1, rd, 32'h8000_2042);
        access(1'b0, 16'h0210, 32'h0, rd, er);
        chk(rd === 32'h0, 2, rd, 32'h0);
        access(1'b0, 16'h0804, 32'h0, rd, er);
        chk(rd === 32'h0 && er === 1'b0, 2, rd, 32'h0);
        // R6: slot 96 toggle alias, then word at 0x800 unaffected
        access(1'b1, 16'h080C, 32'h0000_00F0, rd, er);
        access(1'b0, 16'h0808, 32'h0, rd, er);
        chk(rd === 32'h0000_00F0, 6, rd, 32'h0000_00F0);
        access(1'b0, 16'h0800, 32'h0, rd, er);
        chk(rd === 32'h0072_0010, 6, rd, 32'h0072_0010);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule